// File: doc/BRIEF.md
# Subroutine Call Bus Cycle Sequencer

This block plays out, cycle by cycle, the bus traffic of an 8-bit processor's absolute subroutine call on a 16-bit address bus. It owns the program counter and an 8-bit stack pointer. One pulse on `start` launches a six-cycle sequence:

- an opcode fetch;
- a fetch of the target's low byte into a holding latch;
- a throw-away read of the current stack slot;
- two pushes of the return address, high byte first;
- a final fetch of the target's high byte, which completes the new program counter.

The stack sits in a fixed page, `STACK_PAGE`, which defaults to 0x01. The stack pointer only moves during the two pushes, and it moves downward.

Two details of the sequence deserve attention. The target high byte is read only after both pushes. The pushed value is therefore the address of that high byte, which is the instruction address plus 2, and not the address of the following instruction. A `done` pulse marks completion, and the block then waits in idle for the next `start`. The `pc` and `sp` ports show the register contents at all times.

Top module: `call_seq_top`

## Requirements
- R1: After a synchronous reset, `pc` equals `PC_RESET`, `sp` equals `SP_RESET`, `done` is 0 and `rd_wr_n` is 1 (read) while idle.
- R2: In cycle 1 (the first cycle after `start` is seen in idle), `addr` equals `pc` with a read. `pc` advances by 1 at the end of the cycle.
- R3: In cycle 2, `addr` is the start address + 1 with a read. The `din` byte is captured as the target low byte, and `pc` advances by 1.
- R4: In cycle 3, `addr` equals {STACK_PAGE, sp} with a read. The byte read is discarded and `sp` does not change.
- R5: In cycle 4, the block writes (`rd_wr_n` = 0) bits 15:8 of (start address + 2) on `dout` to {STACK_PAGE, sp}. `sp` then decreases by 1.
- R6: In cycle 5, the block writes bits 7:0 of (start address + 2) to {STACK_PAGE, sp}. `sp` then decreases by 1.
- R7: In cycle 6, `addr` is the start address + 2 with a read. Afterwards `pc` = {din of cycle 6, captured low byte}.
- R8: `rd_wr_n` is 0 only in cycles 4 and 5. `dout` is 0 in every other cycle.
- R9: `done` is 1 for exactly the one cycle after cycle 6, and is 0 otherwise. That cycle is idle, so a `start` in that cycle begins cycle 1 on the next cycle.
- R10: `sp` wraps modulo 256 on decrement, so a write address never leaves the stack page. `pc` wraps modulo 65536 when it increments.
- R11: `start` has no effect while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a call sequence (sampled only in idle) |
| din | input | 8 | Read data from the bus |
| addr | output | 16 | Bus address |
| rd_wr_n | output | 1 | 1 = read cycle, 0 = write cycle |
| dout | output | 8 | Write data, non-zero only in push cycles |
| done | output | 1 | One-cycle completion pulse |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer |

## Verification
Reset is instantiated with `sp` at 0x01, so the second push lands at 0x0100 and the pointer then wraps to 0xFF. A design that borrowed into the page byte, or that saturated, would address page 0x00 or freeze the pointer. One target is 0xFFFE, so the following call's operand fetch wraps `pc` to 0x0000. That pushes a return address of 0x0000, which shows whether the increment wraps correctly.

Every cycle checks the pushed bytes against the instruction address plus 2. This catches a design that pushes plus 3, swaps the push order, or decrements the pointer before the first push. A design that altered `sp` on the dummy read would be caught the same way. The bench also holds `start` high through the middle cycles, and issues a `start` in the `done` cycle. A sequencer that restarted mid-call, or that lost or delayed a back-to-back call, would show a wrong address in the following cycle.

// File: rtl/call_seq_pkg.sv
package call_seq_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_OPC    = 3'd1,
        PH_TLO    = 3'd2,
        PH_DUMMY  = 3'd3,
        PH_PUSH_H = 3'd4,
        PH_PUSH_L = 3'd5,
        PH_THI    = 3'd6
    } phase_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          rd;
        logic [DW-1:0] wdata;
    } bus_t;

    function automatic logic [AW-1:0] stack_addr(input logic [DW-1:0] page,
                                                 input logic [DW-1:0] s);
        return {page, s};
    endfunction

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_OPC:    return PH_TLO;
            PH_TLO:    return PH_DUMMY;
            PH_DUMMY:  return PH_PUSH_H;
            PH_PUSH_H: return PH_PUSH_L;
            PH_PUSH_L: return PH_THI;
            default:   return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/call_seq_ctl.sv
module call_seq_ctl
    import call_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase,
    output logic   done
);
    phase_e phase_q;
    logic   done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_THI);
            if (phase_q == PH_IDLE)
                phase_q <= start ? PH_OPC : PH_IDLE;
            else
                phase_q <= phase_after(phase_q);
        end
    end

    assign phase = phase_q;
    assign done  = done_q;

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_THI) |=> (done_q && phase_q == PH_IDLE));

    // R11
    busy_advances_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_TLO) |=> (phase_q == PH_DUMMY));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && start) |=> (phase_q == PH_OPC));

endmodule

// File: rtl/call_seq_regs.sv
module call_seq_regs
    import call_seq_pkg::*;
#(
    parameter logic [AW-1:0] PC_RESET = 16'h8000,
    parameter logic [DW-1:0] SP_RESET = 8'hFD
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] sp
);
    logic [AW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= PC_RESET;
            sp_q <= SP_RESET;
            lo_q <= '0;
        end else begin
            case (phase)
                PH_OPC:    pc_q <= pc_q + 1'b1;
                PH_TLO: begin
                    lo_q <= din;
                    pc_q <= pc_q + 1'b1;
                end
                PH_PUSH_H,
                PH_PUSH_L: sp_q <= sp_q - 1'b1;
                PH_THI:    pc_q <= {din, lo_q};
                default: ;
            endcase
        end
    end

    assign pc = pc_q;
    assign sp = sp_q;

    // R4
    dummy_keeps_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DUMMY) |=> $stable(sp_q));

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PUSH_H) |=> (sp_q == $past(sp_q) - 8'd1));

    // R7
    target_load_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_THI) |=> (pc_q[15:8] == $past(din)));

endmodule

// File: rtl/call_seq_bus.sv
module call_seq_bus
    import call_seq_pkg::*;
#(
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  phase_e        phase,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] sp,
    output bus_t          bus
);
    always_comb begin
        bus.addr  = pc;
        bus.rd    = 1'b1;
        bus.wdata = '0;
        case (phase)
            PH_DUMMY:  bus.addr = stack_addr(STACK_PAGE, sp);
            PH_PUSH_H: begin
                bus.addr  = stack_addr(STACK_PAGE, sp);
                bus.rd    = 1'b0;
                bus.wdata = pc[AW-1:DW];
            end
            PH_PUSH_L: begin
                bus.addr  = stack_addr(STACK_PAGE, sp);
                bus.rd    = 1'b0;
                bus.wdata = pc[DW-1:0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/call_seq_top.sv
module call_seq_top
    import call_seq_pkg::*;
#(
    parameter logic [15:0] PC_RESET   = 16'h8000,
    parameter logic [7:0]  SP_RESET   = 8'hFD,
    parameter logic [7:0]  STACK_PAGE = 8'h01
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  din,
    output logic [15:0] addr,
    output logic        rd_wr_n,
    output logic [7:0]  dout,
    output logic        done,
    output logic [15:0] pc,
    output logic [7:0]  sp
);
    phase_e phase;
    bus_t   bus;

    call_seq_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .phase (phase),
        .done  (done)
    );

    call_seq_regs #(.PC_RESET(PC_RESET), .SP_RESET(SP_RESET)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .din   (din),
        .pc    (pc),
        .sp    (sp)
    );

    call_seq_bus #(.STACK_PAGE(STACK_PAGE)) u_bus (
        .phase (phase),
        .pc    (pc),
        .sp    (sp),
        .bus   (bus)
    );

    assign addr    = bus.addr;
    assign rd_wr_n = bus.rd;
    assign dout    = bus.wdata;

    // R10
    write_in_page_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_wr_n |-> (addr[15:8] == STACK_PAGE));

    // R8
    dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rd_wr_n |-> (dout == 8'h00));

    // R8
    write_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_wr_n) |=> !rd_wr_n);

endmodule

// File: tb/call_seq_top_tb.sv
module call_seq_top_tb;
    localparam logic [15:0] PCR = 16'hC000;
    localparam logic [7:0]  SPR = 8'h01;
    localparam int NV = 6;
    localparam logic [7:0] VEC [NV][2] = '{
        '{8'h34, 8'h12}, '{8'hFE, 8'hFF}, '{8'h00, 8'h80},
        '{8'hFF, 8'h00}, '{8'h55, 8'hAA}, '{8'h01, 8'h02}};

    logic clk = 0, rst = 1, start = 0;
    logic [7:0] din = 0;
    logic [15:0] addr, pc;
    logic rd_wr_n, done;
    logic [7:0] dout, sp;
    int n_chk = 0, n_bad = 0;
    logic [15:0] mpc;
    logic [7:0]  msp;

    always #10 clk = ~clk;

    call_seq_top #(.PC_RESET(PCR), .SP_RESET(SPR), .STACK_PAGE(8'h01)) u_dut (
        .clk(clk), .rst(rst), .start(start), .din(din), .addr(addr),
        .rd_wr_n(rd_wr_n), .dout(dout), .done(done), .pc(pc), .sp(sp));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_call(input logic [7:0] lo, input logic [7:0] hi,
                            input bit busy_start, input bit launched, input bit chain);
        logic [15:0] ret;
        ret = mpc + 16'd2;
        if (!launched) begin
            @(negedge clk); start = 1;
        end
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            start = (busy_start && c < 5) ? 1'b1 : 1'b0;
            chk("R9 done low in sequence", done, 0);
            case (c)
                1: begin chk("R2 opcode addr", addr, mpc); chk("R2 read", rd_wr_n, 1);
                         chk("R8 dout c1", dout, 0); din = 8'h20; end
                2: begin chk("R3 low addr", addr, mpc + 16'd1); chk("R3 read", rd_wr_n, 1);
                         din = lo; end
                3: begin chk("R4 dummy addr", addr, {8'h01, msp}); chk("R4 read", rd_wr_n, 1);
                         chk("R8 dout c3", dout, 0); din = 8'h5A; end
                4: begin chk("R5 push hi addr", addr, {8'h01, msp}); chk("R5 write", rd_wr_n, 0);
                         chk("R5 push hi data", dout, ret[15:8]); din = 8'hC3; end
                5: begin chk("R6 R10 push lo addr", addr, {8'h01, 8'(msp - 8'd1)});
                         chk("R6 write", rd_wr_n, 0); chk("R6 push lo data", dout, ret[7:0]); end
                default: begin chk("R7 high addr", addr, ret); chk("R7 read", rd_wr_n, 1);
                         chk("R8 dout c6", dout, 0); din = hi; end
            endcase
        end
        @(negedge clk);
        msp = msp - 8'd2;
        mpc = {hi, lo};
        chk("R9 done pulse", done, 1);
        chk("R7 new pc", pc, mpc);
        chk("R10 sp after call", sp, msp);
        chk("R8 idle read", rd_wr_n, 1);
        start = chain;
    endtask

    initial begin
        int wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset pc", pc, PCR);
        chk("R1 reset sp", sp, SPR);
        chk("R1 reset done", done, 0);
        chk("R1 idle read", rd_wr_n, 1);
        mpc = PCR; msp = SPR;
        // R10: first call wraps sp from 01 through 00 to FF
        for (int i = 0; i < NV; i++)
            run_call(VEC[i][0], VEC[i][1], 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R1 idle holds pc", pc, mpc);
        // R11: start held high through the middle of a call
        run_call(8'h78, 8'h56, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 no extra call", addr, mpc);
        chk("R11 still idle sp", sp, msp);
        // R9: back-to-back start issued in the done cycle
        run_call(8'hBC, 8'h9A, 1'b0, 1'b0, 1'b1);
        run_call(8'h11, 8'h22, 1'b0, 1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule